// File: doc/BRIEF.md
# Burst Read Ready Generator

This block sits on the device side of a synchronous burst-read port of a word-addressed memory array. A host opens a burst by pulsing a start strobe with a starting word address while chip enable is held. From then on the block walks the burst address one word per delivered beat. It presents a valid-data strobe and the current address to the array read path. It also drives a ready line that tells the host when data is late.

Wait states are inserted only when a high-frequency flag says the interface clock is above the fast-clock threshold. In that case ready drops at the first access of the burst, and again each time the address leaves a 128-word aligned block. That happens after any word whose low seven address bits are all ones. The number of wait cycles is either one or two, taken from a configuration register that resets to one. When chip enable falls, the ready driver is released and the burst is dropped.

Top module: `burst_rdy_gen`

## Requirements
- R1: After reset the wait-length setting is one cycle, `rdy_o` is high and `data_valid_o` is low.
- R2: `rdy_oe_o` equals `ce_i` on every cycle. While `ce_i` is low, no burst runs and `data_valid_o` stays low from the next cycle onward.
- R3: When a burst starts (`ce_i` and `burst_start_i` high at a clock edge) with `hf_i` high, `rdy_o` is low in the following cycle(s) and `data_valid_o` is low while `rdy_o` is low.
- R4: With the wait setting at one (`cfg_wait2_i`=0 written), each wait episode is exactly one cycle of low `rdy_o`.
- R5: With the wait setting at two (`cfg_we_i`=1, `cfg_wait2_i`=1 written), each wait episode is exactly two consecutive cycles of low `rdy_o`.
- R6: When a burst starts with `hf_i` low, the first word is valid in the very next cycle and `rdy_o` stays high for the whole burst.
- R7: The first valid word carries `addr_o` equal to the start address. Each further valid cycle carries the previous address plus one, wrapping modulo 2^ADDR_W.
- R8: With `hf_i` high, after a valid word whose address has bits [6:0] equal to 7Fh, `rdy_o` drops for the configured wait length before the next word. No wait is inserted at any other address.
- R9: A start strobe during a running burst restarts it at the new address, with the initial-access wait rule applied again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Chip enable |
| burst_start_i | input | 1 | Burst start strobe |
| start_addr_i | input | ADDR_W | Starting word address |
| hf_i | input | 1 | Clock is above the fast-clock threshold |
| cfg_we_i | input | 1 | Write strobe for the wait-length setting |
| cfg_wait2_i | input | 1 | Wait-length value: 0 = one cycle, 1 = two cycles |
| rdy_o | output | 1 | Ready; low means the host must wait |
| rdy_oe_o | output | 1 | Ready driver enable (low models high impedance) |
| data_valid_o | output | 1 | Valid-data strobe to the array read path |
| addr_o | output | ADDR_W | Current burst word address |

## Verification
The embedded assertions check the cycle-local rules on every cycle. They cover the address step after each valid beat, the drop of ready at a burst start or aligned-block exit with the fast flag set, the stretch of a wait to a second cycle under the two-cycle setting, the absence of any wait when the flag is clear, and the loss of valid after chip enable falls. Only the directed scenarios show the whole picture. That includes the exact count of low-ready cycles in each episode and the reset default of one. It also includes whether no wait appears at non-aligned addresses, the address wrap at the top of the space, and a restart in the middle of a burst.

// File: rtl/burst_rdy_pkg.sv
package burst_rdy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DATA = 2'd2
  } burst_state_e;
endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wait2_i,
  output logic wait2_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wait2_o <= 1'b0;
    else if (we_i) wait2_o <= wait2_i;
  end

  // R1
  reset_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i && !$past(we_i) |-> $stable(wait2_o));
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr #(
  parameter int ADDR_W  = 16,
  parameter int BLOCK_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              inc_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              at_edge_o
);
  localparam logic [BLOCK_W-1:0] BLOCK_LAST = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= load_addr_i;
    else if (inc_i)  addr_o <= addr_o + 1'b1;
  end

  assign at_edge_o = (addr_o[BLOCK_W-1:0] == BLOCK_LAST);

  // R7
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !load_i |=> addr_o == $past(addr_o) + 1'b1);
endmodule

// File: rtl/burst_wait_fsm.sv
module burst_wait_fsm
  import burst_rdy_pkg::*;
#(
  parameter int MAX_WAIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic start_i,
  input  logic hf_i,
  input  logic wait2_i,
  input  logic at_edge_i,
  output logic load_o,
  output logic inc_o,
  output logic rdy_o,
  output logic valid_o
);
  localparam int CNT_W = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1;

  burst_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cnt_init;

  // remaining wait cycles minus one
  assign cnt_init = wait2_i ? CNT_W'(1) : CNT_W'(0);
  assign load_o   = ce_i & start_i;
  assign inc_o    = ce_i & ~start_i & (state_q == ST_DATA);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!ce_i) begin
      state_d = ST_IDLE;
    end else if (start_i) begin
      state_d = hf_i ? ST_WAIT : ST_DATA;
      cnt_d   = cnt_init;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (cnt_q == '0) state_d = ST_DATA;
          else             cnt_d   = cnt_q - 1'b1;
        end
        ST_DATA: begin
          if (hf_i && at_edge_i) begin
            state_d = ST_WAIT;
            cnt_d   = cnt_init;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign rdy_o   = (state_q != ST_WAIT);
  assign valid_o = (state_q == ST_DATA);

  // R2
  ce_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> !valid_o);
  // R3
  init_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && start_i && hf_i |=> !rdy_o);
  // R5
  two_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) && wait2_i && $stable(wait2_i) && ce_i && !start_i |=> !rdy_o);
  // R6
  no_hf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && start_i && !hf_i |=> rdy_o && valid_o);
  // R8
  edge_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && at_edge_i && hf_i && ce_i && !start_i |=> !rdy_o);
endmodule

// File: rtl/burst_rdy_gen.sv
module burst_rdy_gen #(
  parameter int ADDR_W   = 16,
  parameter int BLOCK_W  = 7,
  parameter int MAX_WAIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              burst_start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              hf_i,
  input  logic              cfg_we_i,
  input  logic              cfg_wait2_i,
  output logic              rdy_o,
  output logic              rdy_oe_o,
  output logic              data_valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic wait2, load, inc, at_edge;

  burst_cfg_reg i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wait2_i (cfg_wait2_i),
    .wait2_o (wait2)
  );

  burst_addr_ctr #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) i_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .inc_i       (inc),
    .load_addr_i (start_addr_i),
    .addr_o      (addr_o),
    .at_edge_o   (at_edge)
  );

  burst_wait_fsm #(.MAX_WAIT(MAX_WAIT)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_i      (ce_i),
    .start_i   (burst_start_i),
    .hf_i      (hf_i),
    .wait2_i   (wait2),
    .at_edge_i (at_edge),
    .load_o    (load),
    .inc_o     (inc),
    .rdy_o     (rdy_o),
    .valid_o   (data_valid_o)
  );

  assign rdy_oe_o = ce_i;

  // R2
  oe_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_oe_o == ce_i);
  // R3
  no_data_in_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o |-> !data_valid_o);
endmodule

// File: tb/test_burst_rdy_gen.sv
module test_burst_rdy_gen;
  localparam int AW = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ce_i = 1'b0, burst_start_i = 1'b0, hf_i = 1'b0;
  logic cfg_we_i = 1'b0, cfg_wait2_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic rdy_o, rdy_oe_o, data_valid_o;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  burst_rdy_gen #(.ADDR_W(AW)) i_burst_rdy_gen (
    .clk_i, .rst_ni, .ce_i, .burst_start_i, .start_addr_i, .hf_i,
    .cfg_we_i, .cfg_wait2_i, .rdy_o, .rdy_oe_o, .data_valid_o, .addr_o
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  // expect a wait cycle, then advance
  task automatic exp_wait(string req);
    chk(req, "rdy low", int'(rdy_o), 0);
    chk(req, "valid low in wait", int'(data_valid_o), 0);
    tick();
  endtask

  task automatic exp_word(string req, int a);
    chk(req, "rdy high", int'(rdy_o), 1);
    chk(req, "valid", int'(data_valid_o), 1);
    chk(req, "addr", int'(addr_o), a);
    tick();
  endtask

  task automatic start(logic hf, int a);
    ce_i = 1'b1; hf_i = hf; start_addr_i = AW'(a); burst_start_i = 1'b1;
    tick();
    burst_start_i = 1'b0;
  endtask

  task automatic set_wait(logic w2);
    cfg_we_i = 1'b1; cfg_wait2_i = w2;
    tick();
    cfg_we_i = 1'b0;
  endtask

  task automatic end_burst();
    ce_i = 1'b0; hf_i = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    chk("R1", "rdy after reset", int'(rdy_o), 1);
    chk("R1", "valid after reset", int'(data_valid_o), 0);
    chk("R2", "oe with ce low", int'(rdy_oe_o), 0);
  endtask

  task automatic t_default_wait();
    // R1 R4: default is one wait cycle
    start(1'b1, 'h0040);
    exp_wait("R4");
    exp_word("R1", 'h0040);
    exp_word("R7", 'h0041);
    exp_word("R7", 'h0042);
    end_burst();
  endtask

  task automatic t_two_wait();
    set_wait(1'b1);
    start(1'b1, 'h1230);
    exp_wait("R5");
    exp_wait("R5");
    exp_word("R5", 'h1230);
    exp_word("R7", 'h1231);
    end_burst();
    set_wait(1'b0);
  endtask

  task automatic t_no_hf();
    start(1'b0, 'h007D);
    for (int i = 0; i < 5; i++) exp_word("R6", 'h007D + i);
    end_burst();
  endtask

  task automatic t_edge_one();
    start(1'b1, 'h017E);
    exp_wait("R3");
    exp_word("R8", 'h017E);
    exp_word("R8", 'h017F);
    exp_wait("R8");
    exp_word("R8", 'h0180);
    exp_word("R8", 'h0181);
    end_burst();
  endtask

  task automatic t_edge_two();
    set_wait(1'b1);
    start(1'b1, 'h00FF);
    exp_wait("R5");
    exp_wait("R5");
    exp_word("R8", 'h00FF);
    exp_wait("R8");
    exp_wait("R8");
    exp_word("R8", 'h0100);
    end_burst();
    set_wait(1'b0);
  endtask

  task automatic t_mid_block();
    // R8: no wait away from the block edge
    start(1'b1, 'h0010);
    exp_wait("R3");
    for (int i = 0; i < 20; i++) exp_word("R8", 'h0010 + i);
    end_burst();
  endtask

  task automatic t_wrap();
    start(1'b0, 'hFFFE);
    exp_word("R7", 'hFFFE);
    exp_word("R7", 'hFFFF);
    exp_word("R7", 'h0000);
    end_burst();
  endtask

  task automatic t_ce_drop();
    start(1'b0, 'h0200);
    exp_word("R2", 'h0200);
    ce_i = 1'b0;
    tick();
    chk("R2", "oe low", int'(rdy_oe_o), 0);
    chk("R2", "valid after ce drop", int'(data_valid_o), 0);
    ce_i = 1'b1;
    tick();
    chk("R2", "oe high", int'(rdy_oe_o), 1);
    chk("R2", "burst abandoned", int'(data_valid_o), 0);
    tick();
    chk("R2", "still abandoned", int'(data_valid_o), 0);
    end_burst();
  endtask

  task automatic t_restart();
    start(1'b0, 'h0300);
    exp_word("R9", 'h0300);
    start(1'b1, 'h0500);
    exp_wait("R9");
    exp_word("R9", 'h0500);
    end_burst();
  endtask

  initial begin
    tick();
    tick();
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_default_wait();
    t_two_wait();
    t_no_hf();
    t_edge_one();
    t_edge_two();
    t_mid_block();
    t_wrap();
    t_ce_drop();
    t_restart();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule